// File: doc/BRIEF.md
# Fractional-N Modulus Controller with Ripple Compensation

This block sequences the main divider of a fractional-N frequency synthesiser, one comparison cycle at a time. It holds an integer divide value and a fractional numerator. It also keeps a residue accumulator whose modulus is selected at run time as 5 or 8. On each comparison strobe the numerator is added to the residue, modulo the active modulus.

A strobe whose addition wraps past the modulus commands the divider to count one extra VCO period (divide by N+1). Every other strobe commands divide by N. Together with the divide command, the block produces a digital compensation code for an auxiliary cancellation charge pump. The code is the product of the residue and a loop-dynamics scale factor.

The proportional pump current tracks the integer divide value. Because of that, the code needs only the scale factor and never the divide value itself. Normalisation by the modulus is left to the pump weighting, which is keyed by the same modulus choice. A second scale factor is used while the loop is in fast-acquisition mode.

New settings are captured into a pending set whenever `load` pulses. They become active at the next comparison strobe, which also zeroes the residue. That zero-residue cycle is the reference phase, so its compensation code is zero.

Top module: `fracn_modctl`

## Requirements
- R1: While reset is held and after its release, `divide_sel`, `div_value`, `comp_code` and `nf_err` are all zero.
- R2: On each strobe without a pending load, the residue becomes (residue + numerator) mod M, where M is 8 when the modulus choice is 1 and 5 when it is 0. With M = 8, numerator 3 and residue 0, the residues run 3, 6, 1, 4, 7, 2, 5, 0.
- R3: `divide_sel` is 1 exactly for a strobe whose addition reached or exceeded M, and 0 otherwise. `div_value` equals the active integer value plus `divide_sel`.
- R4: With modulus choice 0 (M = 5), numerator 2 and residue 0, the residues run 2, 4, 1, 3, 0, and wraps occur on the steps into 1 and into 0.
- R5: `comp_code` equals the new residue times `sf_norm` when `speedup` is 0, and it is zero whenever the residue is zero.
- R6: When `speedup` is 1 at the strobe, `comp_code` equals the new residue times `sf_fast`.
- R7: All outputs except `nf_err` change only on a clock edge where `cmp_stb` is 1. They are visible one clock after the strobe.
- R8: A `load` pulse does not alter `divide_sel`, `div_value` or `comp_code`. The next strobe, and not a strobe in the same cycle as the load, applies the loaded values, clears the residue and gives `divide_sel` = 0, `comp_code` = 0 and `div_value` = the new integer value.
- R9: A loaded numerator that is greater than or equal to M is stored as M-1, and `nf_err` is set to 1. A later load with a numerator below M clears `nf_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_stb | input | 1 | One-cycle comparison-cycle strobe |
| load | input | 1 | Capture new settings into the pending set |
| ld_ntot | input | NTOT_W | Integer divide value to load |
| ld_nf | input | NF_W | Fractional numerator to load |
| ld_mod8 | input | 1 | Modulus choice to load: 1 = 8, 0 = 5 |
| speedup | input | 1 | Selects the fast-acquisition scale factor |
| sf_norm | input | SF_W | Scale factor, normal mode |
| sf_fast | input | SF_W | Scale factor, fast-acquisition mode |
| divide_sel | output | 1 | 0 = divide by N, 1 = divide by N+1 |
| div_value | output | NTOT_W+1 | Divide value for this cycle |
| comp_code | output | NF_W+SF_W | Cancellation pump magnitude |
| nf_err | output | 1 | Last loaded numerator was clamped |

## Verification
The bench builds the block with its defaults: a 12-bit integer value, a 3-bit numerator and 8-bit scale factors. Those widths cover every numerator for both moduli. The largest product, 7 × 255, fits the code width exactly. An integer value of 4095 exercises the carry into the extra `div_value` bit. Because the numerator field is 3 bits, every out-of-range case (5, 6 and 7 under modulus 5) can be reached and clamped.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  // The two residue moduli the controller supports.
  localparam int unsigned MOD_LO = 5;
  localparam int unsigned MOD_HI = 8;

  // Modulus value for a modulus-choice bit, in a given width.
  function automatic int unsigned mod_of(input logic hi);
    return hi ? MOD_HI : MOD_LO;
  endfunction

endpackage

// File: rtl/fracn_cfg.sv
// Pending/active settings. A load fills the pending set. The next strobe
// copies it into the active set and requests a residue clear.
module fracn_cfg
  import fracn_pkg::*;
#(
  parameter int unsigned NTOT_W = 12,
  parameter int unsigned NF_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_stb,
  input  logic              load,
  input  logic [NTOT_W-1:0] ld_ntot,
  input  logic [NF_W-1:0]   ld_nf,
  input  logic              ld_mod8,
  output logic              apply,
  output logic              pend_q,
  output logic [NF_W-1:0]   pend_nf_q,
  output logic              pend_mod8_q,
  output logic [NTOT_W-1:0] ntot_nx,
  output logic [NTOT_W-1:0] act_ntot_q,
  output logic [NF_W-1:0]   act_nf_q,
  output logic              act_mod8_q,
  output logic              nf_err
);

  localparam int unsigned CW = NF_W + 1;

  logic [NTOT_W-1:0] pend_ntot_q, pend_ntot_d;
  logic [NF_W-1:0]   pend_nf_d;
  logic              pend_mod8_d, pend_d;
  logic              err_d;
  logic [NTOT_W-1:0] act_ntot_d;
  logic [NF_W-1:0]   act_nf_d;
  logic              act_mod8_d;
  logic [CW-1:0]     lim;
  logic              too_big;

  assign apply = cmp_stb & pend_q;

  // Clamp an out-of-range numerator to the largest legal value.
  always_comb begin
    lim     = CW'(mod_of(ld_mod8));
    too_big = ({1'b0, ld_nf} >= lim);
  end

  always_comb begin
    pend_ntot_d = pend_ntot_q;
    pend_nf_d   = pend_nf_q;
    pend_mod8_d = pend_mod8_q;
    err_d       = nf_err;
    pend_d      = pend_q;
    if (apply) pend_d = 1'b0;
    if (load) begin
      pend_d      = 1'b1;
      pend_ntot_d = ld_ntot;
      pend_mod8_d = ld_mod8;
      err_d       = too_big;
      pend_nf_d   = too_big ? NF_W'(lim - CW'(1)) : ld_nf;
    end
  end

  always_comb begin
    act_ntot_d = act_ntot_q;
    act_nf_d   = act_nf_q;
    act_mod8_d = act_mod8_q;
    if (apply) begin
      act_ntot_d = pend_ntot_q;
      act_nf_d   = pend_nf_q;
      act_mod8_d = pend_mod8_q;
    end
  end

  assign ntot_nx = act_ntot_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_ntot_q <= '0;
      pend_nf_q   <= '0;
      pend_mod8_q <= 1'b0;
      nf_err      <= 1'b0;
      act_ntot_q  <= '0;
      act_nf_q    <= '0;
      act_mod8_q  <= 1'b0;
    end else begin
      pend_q      <= pend_d;
      pend_ntot_q <= pend_ntot_d;
      pend_nf_q   <= pend_nf_d;
      pend_mod8_q <= pend_mod8_d;
      nf_err      <= err_d;
      act_ntot_q  <= act_ntot_d;
      act_nf_q    <= act_nf_d;
      act_mod8_q  <= act_mod8_d;
    end
  end

endmodule

// File: rtl/fracn_accum.sv
// Residue accumulator with wrap detection, advanced once per strobe.
module fracn_accum
  import fracn_pkg::*;
#(
  parameter int unsigned NF_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb,
  input  logic            clear,
  input  logic [NF_W-1:0] nf,
  input  logic            mod8,
  output logic [NF_W-1:0] acc_nx,
  output logic            wrap_nx,
  output logic [NF_W-1:0] acc_q,
  output logic            sel_q
);

  localparam int unsigned SW = NF_W + 1;

  logic [SW-1:0]   sum, modv;
  logic [NF_W-1:0] acc_d;
  logic            sel_d;

  always_comb begin
    modv    = SW'(mod_of(mod8));
    sum     = {1'b0, acc_q} + {1'b0, nf};
    wrap_nx = 1'b0;
    acc_nx  = NF_W'(sum);
    if (clear) begin
      acc_nx = '0;
    end else if (sum >= modv) begin
      wrap_nx = 1'b1;
      acc_nx  = NF_W'(sum - modv);
    end
  end

  always_comb begin
    acc_d = acc_q;
    sel_d = sel_q;
    if (stb) begin
      acc_d = acc_nx;
      sel_d = wrap_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      sel_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      sel_q <= sel_d;
    end
  end

endmodule

// File: rtl/fracn_comp.sv
// Registers the divide value and the cancellation code for each strobe.
module fracn_comp #(
  parameter int unsigned NTOT_W = 12,
  parameter int unsigned NF_W   = 3,
  parameter int unsigned SF_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb,
  input  logic [NF_W-1:0]      acc_nx,
  input  logic                 wrap_nx,
  input  logic [NTOT_W-1:0]    ntot_nx,
  input  logic                 speedup,
  input  logic [SF_W-1:0]      sf_norm,
  input  logic [SF_W-1:0]      sf_fast,
  output logic [NTOT_W:0]      div_value,
  output logic [NF_W+SF_W-1:0] comp_code
);

  localparam int unsigned DW = NTOT_W + 1;
  localparam int unsigned CW = NF_W + SF_W;

  logic [SF_W-1:0] sf_use;
  logic [DW-1:0]   div_d;
  logic [CW-1:0]   comp_d;

  always_comb begin
    sf_use = speedup ? sf_fast : sf_norm;
    div_d  = div_value;
    comp_d = comp_code;
    if (stb) begin
      div_d  = {1'b0, ntot_nx} + DW'(wrap_nx);
      comp_d = CW'(acc_nx) * CW'(sf_use);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_value <= '0;
      comp_code <= '0;
    end else begin
      div_value <= div_d;
      comp_code <= comp_d;
    end
  end

endmodule

// File: rtl/fracn_modctl.sv
module fracn_modctl #(
  parameter int unsigned NTOT_W = 12,
  parameter int unsigned NF_W   = 3,
  parameter int unsigned SF_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmp_stb,
  input  logic                 load,
  input  logic [NTOT_W-1:0]    ld_ntot,
  input  logic [NF_W-1:0]      ld_nf,
  input  logic                 ld_mod8,
  input  logic                 speedup,
  input  logic [SF_W-1:0]      sf_norm,
  input  logic [SF_W-1:0]      sf_fast,
  output logic                 divide_sel,
  output logic [NTOT_W:0]      div_value,
  output logic [NF_W+SF_W-1:0] comp_code,
  output logic                 nf_err
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  logic              apply, pend_q, pend_mod8_q, act_mod8_q, wrap_nx;
  logic [NF_W-1:0]   pend_nf_q, act_nf_q, acc_nx, acc_q;
  logic [NTOT_W-1:0] ntot_nx, act_ntot_q;

  fracn_cfg #(.NTOT_W(NTOT_W), .NF_W(NF_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_sync), .cmp_stb(cmp_stb), .load(load),
    .ld_ntot(ld_ntot), .ld_nf(ld_nf), .ld_mod8(ld_mod8),
    .apply(apply), .pend_q(pend_q), .pend_nf_q(pend_nf_q),
    .pend_mod8_q(pend_mod8_q), .ntot_nx(ntot_nx), .act_ntot_q(act_ntot_q),
    .act_nf_q(act_nf_q), .act_mod8_q(act_mod8_q), .nf_err(nf_err)
  );

  fracn_accum #(.NF_W(NF_W)) u_acc (
    .clk(clk), .rst_n(rst_n_sync), .stb(cmp_stb), .clear(apply),
    .nf(act_nf_q), .mod8(act_mod8_q), .acc_nx(acc_nx), .wrap_nx(wrap_nx),
    .acc_q(acc_q), .sel_q(divide_sel)
  );

  fracn_comp #(.NTOT_W(NTOT_W), .NF_W(NF_W), .SF_W(SF_W)) u_comp (
    .clk(clk), .rst_n(rst_n_sync), .stb(cmp_stb), .acc_nx(acc_nx),
    .wrap_nx(wrap_nx), .ntot_nx(ntot_nx), .speedup(speedup),
    .sf_norm(sf_norm), .sf_fast(sf_fast), .div_value(div_value),
    .comp_code(comp_code)
  );

endmodule

// File: rtl/fracn_modctl_chk.sv
module fracn_modctl_chk
  import fracn_pkg::*;
#(
  parameter int unsigned NTOT_W = 12,
  parameter int unsigned NF_W   = 3,
  parameter int unsigned SF_W   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmp_stb,
  input logic                 apply,
  input logic [NF_W-1:0]      acc_q,
  input logic                 act_mod8_q,
  input logic [NF_W-1:0]      pend_nf_q,
  input logic                 pend_mod8_q,
  input logic                 divide_sel,
  input logic [NTOT_W:0]      div_value,
  input logic [NTOT_W-1:0]    act_ntot_q,
  input logic [NF_W+SF_W-1:0] comp_code
);

  // R2: residue stays below the active modulus
  a_r2_acc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, acc_q} < (NF_W+1)'(mod_of(act_mod8_q))));

  // R3: divide value tracks the active integer value plus the select
  a_r3_div_value: assert property (@(posedge clk) disable iff (!rst_n)
    (div_value == ({1'b0, act_ntot_q} + (NTOT_W+1)'(divide_sel))));

  // R5: zero residue gives zero compensation
  a_r5_zero_comp: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == '0) |-> (comp_code == '0));

  // R7: no strobe, no output change
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_stb |=> ($stable(divide_sel) && $stable(div_value) && $stable(comp_code)));

  // R8: applying a load clears residue and selects divide by N
  a_r8_apply_clear: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (acc_q == '0 && !divide_sel && comp_code == '0));

  // R9: stored numerator is always legal for its modulus
  a_r9_nf_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, pend_nf_q} < (NF_W+1)'(mod_of(pend_mod8_q))));

endmodule

bind fracn_modctl fracn_modctl_chk #(.NTOT_W(NTOT_W), .NF_W(NF_W), .SF_W(SF_W)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .cmp_stb(cmp_stb), .apply(apply),
  .acc_q(acc_q), .act_mod8_q(act_mod8_q), .pend_nf_q(pend_nf_q),
  .pend_mod8_q(pend_mod8_q), .divide_sel(divide_sel), .div_value(div_value),
  .act_ntot_q(act_ntot_q), .comp_code(comp_code)
);

// File: tb/fracn_modctl_test.sv
module fracn_modctl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NTOT_W = 12;
  localparam int NF_W   = 3;
  localparam int SF_W   = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 cmp_stb = 1'b0, load = 1'b0, ld_mod8 = 1'b0, speedup = 1'b0;
  logic [NTOT_W-1:0]    ld_ntot = '0;
  logic [NF_W-1:0]      ld_nf = '0;
  logic [SF_W-1:0]      sf_norm = '0, sf_fast = '0;
  logic                 divide_sel, nf_err;
  logic [NTOT_W:0]      div_value;
  logic [NF_W+SF_W-1:0] comp_code;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Bench model of the requirements.
  int m_acc = 0, m_nf = 0, m_mod = 5, m_ntot = 0;
  int p_nf = 0, p_mod = 5, p_ntot = 0;
  bit m_pend = 0;
  int e_sel = 0, e_div = 0, e_comp = 0, e_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracn_modctl #(.NTOT_W(NTOT_W), .NF_W(NF_W), .SF_W(SF_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_stb(cmp_stb), .load(load),
    .ld_ntot(ld_ntot), .ld_nf(ld_nf), .ld_mod8(ld_mod8), .speedup(speedup),
    .sf_norm(sf_norm), .sf_fast(sf_fast), .divide_sel(divide_sel),
    .div_value(div_value), .comp_code(comp_code), .nf_err(nf_err)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "divide_sel", int'(divide_sel), e_sel);
    chk(req, "div_value", int'(div_value), e_div);
    chk(req, "comp_code", int'(comp_code), e_comp);
    chk(req, "nf_err", int'(nf_err), e_err);
  endtask

  task automatic do_load(input int ntot, input int nf, input bit m8);
    @(negedge clk);
    load = 1'b1; ld_ntot = NTOT_W'(ntot); ld_nf = NF_W'(nf); ld_mod8 = m8;
    @(negedge clk);
    load = 1'b0;
    p_mod = m8 ? 8 : 5;
    p_ntot = ntot;
    e_err = (nf >= p_mod) ? 1 : 0;
    p_nf  = (nf >= p_mod) ? p_mod - 1 : nf;
    m_pend = 1;
  endtask

  // Model one strobe's effect.
  task automatic model_step();
    int sum;
    if (m_pend) begin
      m_ntot = p_ntot; m_nf = p_nf; m_mod = p_mod; m_acc = 0; e_sel = 0; m_pend = 0;
    end else begin
      sum = m_acc + m_nf;
      e_sel = (sum >= m_mod) ? 1 : 0;
      m_acc = e_sel ? sum - m_mod : sum;
    end
    e_div  = m_ntot + e_sel;
    e_comp = m_acc * (speedup ? int'(sf_fast) : int'(sf_norm));
  endtask

  task automatic strobe(input string req);
    @(negedge clk);
    cmp_stb = 1'b1;
    @(negedge clk);
    cmp_stb = 1'b0;
    model_step();
    chk_all(req);
  endtask

  task automatic t_reset();
    chk_all("R1");
    chk("R1", "div_value", int'(div_value), 0);
  endtask

  task automatic t_mod8_sequence();
    int exp_acc[8] = '{3, 6, 1, 4, 7, 2, 5, 0};
    int exp_sel[8] = '{0, 0, 1, 0, 0, 1, 0, 1};
    sf_norm = 8'd10; speedup = 1'b0;
    do_load(100, 3, 1'b1);
    strobe("R8");
    for (int i = 0; i < 8; i++) begin
      strobe("R2");
      chk("R3", "divide_sel literal", int'(divide_sel), exp_sel[i]);
      chk("R3", "div_value literal", int'(div_value), 100 + exp_sel[i]);
      chk("R5", "comp_code literal", int'(comp_code), exp_acc[i] * 10);
    end
  endtask

  task automatic t_mod5_sequence();
    int exp_acc[5] = '{2, 4, 1, 3, 0};
    int exp_sel[5] = '{0, 0, 1, 0, 1};
    sf_norm = 8'd7;
    do_load(4095, 2, 1'b0);
    strobe("R8");
    for (int i = 0; i < 5; i++) begin
      strobe("R4");
      chk("R4", "divide_sel literal", int'(divide_sel), exp_sel[i]);
      chk("R4", "comp_code literal", int'(comp_code), exp_acc[i] * 7);
      chk("R3", "div_value carry", int'(div_value), 4095 + exp_sel[i]);
    end
  endtask

  task automatic t_speedup();
    sf_norm = 8'd3; sf_fast = 8'd255;
    do_load(50, 7, 1'b1);
    strobe("R8");
    speedup = 1'b1;
    strobe("R6");
    chk("R6", "comp fast literal", int'(comp_code), 7 * 255);
    speedup = 1'b0;
    strobe("R5");
    chk("R5", "comp normal literal", int'(comp_code), 6 * 3);
  endtask

  task automatic t_hold_and_load();
    int s_sel, s_div, s_comp;
    s_sel = int'(divide_sel); s_div = int'(div_value); s_comp = int'(comp_code);
    repeat (5) @(negedge clk);
    chk("R7", "idle divide_sel", int'(divide_sel), s_sel);
    chk("R7", "idle comp_code", int'(comp_code), s_comp);
    do_load(200, 1, 1'b1);
    repeat (2) @(negedge clk);
    chk("R8", "load no strobe div", int'(div_value), s_div);
    chk("R8", "load no strobe comp", int'(comp_code), s_comp);
    strobe("R8");
    chk("R8", "apply div literal", int'(div_value), 200);
    chk("R8", "apply comp literal", int'(comp_code), 0);
    strobe("R2");
  endtask

  task automatic t_load_with_strobe();
    // Same-cycle load and strobe: the strobe steps with the old settings.
    sf_norm = 8'd1;
    @(negedge clk);
    load = 1'b1; ld_ntot = 12'd300; ld_nf = 3'd4; ld_mod8 = 1'b1; cmp_stb = 1'b1;
    @(negedge clk);
    load = 1'b0; cmp_stb = 1'b0;
    model_step();
    p_mod = 8; p_ntot = 300; p_nf = 4; e_err = 0; m_pend = 1;
    chk_all("R8");
    strobe("R8");
    chk("R8", "deferred apply literal", int'(div_value), 300);
    strobe("R2");
    chk("R2", "after deferred apply", int'(comp_code), 4);
  endtask

  task automatic t_clamp();
    sf_norm = 8'd2;
    do_load(60, 6, 1'b0);
    chk("R9", "nf_err set", int'(nf_err), 1);
    strobe("R9");
    strobe("R9");
    chk("R9", "clamped step literal", int'(comp_code), 4 * 2);
    strobe("R9");
    chk("R9", "clamped wrap literal", int'(divide_sel), 1);
    chk("R9", "clamped residue literal", int'(comp_code), 3 * 2);
    do_load(60, 7, 1'b1);
    chk("R9", "nf_err cleared", int'(nf_err), 0);
    strobe("R9");
    strobe("R9");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mod8_sequence();
    t_mod5_sequence();
    t_speedup();
    t_hold_and_load();
    t_load_with_strobe();
    t_clamp();
    finish_run();
  end

endmodule